// File: doc/BRIEF.md
# Host-to-Controller Mailbox Interface

This block sits between a host processor bus and a small slave controller and gives them a two-way, one-byte mailbox. There are two data registers. The host writes the inbound byte and the slave reads it. The slave loads the outbound byte and the host reads it. A four-bit status word carries the handshake. Two of its bits show whether each data register holds an unconsumed byte. One bit records whether the host's last write was a command or data. The last bit is a general-purpose flag that only the slave controls.

The host side uses strobes: a chip select, a read strobe, a write strobe and one address bit. Writes and data reads take effect when the strobe is released. Each strobe is synchronised into the slave clock domain, and a host access commits exactly `SYNC_STAGES` clocks after the first rising edge that samples the released strobe. The host must hold its address and write data steady until then.

The slave side is fully synchronous to `clk`. It has single-cycle load and read pulses, the inbound byte on a plain output, and the flags brought out as individual signals.

Top module: `hmb_mailbox`

## Requirements
- R1: While `rst` is high, and after it, until the first access, all four flags and both data registers are zero. A host status read and a host data read then return 0.
- R2: A `sl_load` pulse stores `sl_odata` in the outbound register and sets the outbound-full flag (status bit 0) on the next clock. A later host read with A0=0 returns that byte.
- R3: A host read with A0=0 clears the outbound-full flag when it commits. A host read never returns a byte that the host itself wrote.
- R4: A host write stores `host_wdata` in the inbound register and sets the inbound-full flag (status bit 1), shown on `sl_idata` and `sl_ibf`. A `sl_read` pulse clears that flag on the next clock.
- R5: Every host write loads the command flag (status bit 3, `sl_cmd`) with A0: 1 marks a command and 0 marks data. Nothing else changes it.
- R6: The general flag (status bit 2) changes only when `sl_f0_we` is high, when it takes `sl_f0_val`. Host writes never change it.
- R7: A host read with A0=1 returns {zeros, F1, F0, IBF, OBF} in bits 3..0, with upper bits zero. It changes no flag.
- R8: A host write leaves the outbound byte and its flag untouched. A slave load leaves the inbound byte and its flag untouched.
- R9: A host write while the inbound flag is set replaces the byte and keeps the flag set. A slave load while the outbound flag is set does the same for the outbound byte.
- R10: While a strobe is held, no flag changes. The update lands on the `SYNC_STAGES`-th rising edge after the first edge that sees the strobe low.
- R11: If a slave load and a host data-read commit fall in the same cycle, the outbound flag ends set. If a host write commit and a slave read fall in the same cycle, the inbound flag ends set.
- R12: Without chip select, strobes have no effect and `host_rdata` stays 0. `host_rdata` is also 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_a0 | input | 1 | Host address bit: 0 data, 1 status/command |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, zero when not reading |
| sl_load | input | 1 | Slave pulse: load outbound byte |
| sl_odata | input | DATA_W | Slave outbound byte |
| sl_read | input | 1 | Slave pulse: consume inbound byte |
| sl_idata | output | DATA_W | Inbound byte held for the slave |
| sl_f0_we | input | 1 | Slave write enable for the general flag |
| sl_f0_val | input | 1 | Value for the general flag |
| sl_obf | output | 1 | Outbound-full flag |
| sl_ibf | output | 1 | Inbound-full flag |
| sl_cmd | output | 1 | Command/data tag of the last host write |

## Verification
Two pairs of functions can coincide in one cycle. A host data-read commit can meet a slave load, and both act on the outbound flag. A host write commit can meet a slave read, and both act on the inbound flag. The bench releases the host strobe and then places the slave pulse at each offset from zero to five clocks, so one offset lands exactly on the commit edge. For every offset it predicts the final flag from the order of the two edges, with the slave load or the host write winning a tie, and compares that prediction with the flag and the byte read back.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

    localparam int STAT_W  = 4;
    localparam int OBF_BIT = 0;
    localparam int IBF_BIT = 1;
    localparam int F0_BIT  = 2;
    localparam int F1_BIT  = 3;

    // packed MSB first: f1 is bit 3, obf is bit 0
    typedef struct packed {
        logic f1;
        logic f0;
        logic ibf;
        logic obf;
    } hmb_status_t;

    // one-cycle host commit events, already in the clk domain
    typedef struct packed {
        logic wr_done;
        logic rd_done;
        logic tag;
    } hmb_host_evt_t;

    typedef enum logic [1:0] {
        SEL_IDLE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STATUS = 2'd2
    } hmb_rsel_e;

    function automatic hmb_rsel_e read_select(input logic cs, input logic rd, input logic a0);
        if (!(cs && rd)) return SEL_IDLE;
        return a0 ? SEL_STATUS : SEL_DATA;
    endfunction

    function automatic logic data_read_commit(input hmb_host_evt_t e);
        return e.rd_done && !e.tag;
    endfunction

endpackage

// File: rtl/hmb_strobe_sync.sv
module hmb_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic released
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              seen_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain     <= '0;
            seen_high <= 1'b0;
        end else begin
            chain     <= {chain[STAGES-2:0], strobe_async};
            seen_high <= chain[LAST];
        end
    end

    // release event: synchronised strobe was high, now low
    assign released = seen_high && !chain[LAST];

    AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        released |=> !released); // R10

endmodule

// File: rtl/hmb_host_port.sv
module hmb_host_port
    import hmb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_cs,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic               host_a0,
    input  logic [DATA_W-1:0]  host_wdata,
    input  hmb_status_t        status,
    input  logic [DATA_W-1:0]  out_byte,
    output logic [DATA_W-1:0]  host_rdata,
    output hmb_host_evt_t      evt,
    output logic [DATA_W-1:0]  wr_byte
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic wr_qual, rd_qual;
    logic wr_rel, rd_rel;

    assign wr_qual = host_cs && host_wr;
    assign rd_qual = host_cs && host_rd;

    hmb_strobe_sync #(.STAGES(STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_async(wr_qual), .released(wr_rel)
    );

    hmb_strobe_sync #(.STAGES(STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_async(rd_qual), .released(rd_rel)
    );

    // address and write data are held by the host until commit
    always_comb begin
        evt.wr_done = wr_rel;
        evt.rd_done = rd_rel;
        evt.tag     = host_a0;
        wr_byte     = host_wdata;
    end

    always_comb begin
        unique case (read_select(host_cs, host_rd, host_a0))
            SEL_DATA:   host_rdata = out_byte;
            SEL_STATUS: host_rdata = {{PAD_W{1'b0}}, status};
            default:    host_rdata = '0;
        endcase
    end

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !host_rd |-> host_rdata == '0); // R12

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_cs && host_rd && host_a0) |-> host_rdata[DATA_W-1:STAT_W] == '0); // R7

endmodule

// File: rtl/hmb_flag_unit.sv
module hmb_flag_unit
    import hmb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  hmb_host_evt_t evt,
    input  logic          sl_load,
    input  logic          sl_read,
    input  logic          sl_f0_we,
    input  logic          sl_f0_val,
    output hmb_status_t   status
);
    hmb_status_t nxt;

    always_comb begin
        nxt = status;
        // outbound flag: slave load wins over a same-cycle host data read
        if (sl_load)                     nxt.obf = 1'b1;
        else if (data_read_commit(evt))  nxt.obf = 1'b0;
        // inbound flag: host write wins over a same-cycle slave read
        if (evt.wr_done)                 nxt.ibf = 1'b1;
        else if (sl_read)                nxt.ibf = 1'b0;
        if (evt.wr_done)                 nxt.f1  = evt.tag;
        if (sl_f0_we)                    nxt.f0  = sl_f0_val;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= nxt;
    end

    AST_OBF_SET_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        sl_load |=> status.obf); // R11

    AST_OBF_CLR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_done && !evt.tag && !sl_load) |=> !status.obf); // R3

    AST_IBF_SET_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        evt.wr_done |=> status.ibf); // R11

    AST_IBF_CLR_ON_SLAVE: assert property (@(posedge clk) disable iff (rst)
        (sl_read && !evt.wr_done) |=> !status.ibf); // R4

    AST_F1_FOLLOWS_A0: assert property (@(posedge clk) disable iff (rst)
        evt.wr_done |=> status.f1 == $past(evt.tag)); // R5

    AST_F1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt.wr_done |=> $stable(status.f1)); // R5

    AST_F0_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sl_f0_we |=> $stable(status.f0)); // R6

    AST_STATUS_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_done && evt.tag && !sl_load && !sl_read && !sl_f0_we && !evt.wr_done)
        |=> $stable(status)); // R7

endmodule

// File: rtl/hmb_data_regs.sv
module hmb_data_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_commit,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              sl_load,
    input  logic [DATA_W-1:0] sl_odata,
    output logic [DATA_W-1:0] in_byte,
    output logic [DATA_W-1:0] out_byte
);
    // two separate registers: neither direction can disturb the other
    always_ff @(posedge clk) begin
        if (rst) begin
            in_byte  <= '0;
            out_byte <= '0;
        end else begin
            if (wr_commit) in_byte  <= wr_byte;
            if (sl_load)   out_byte <= sl_odata;
        end
    end

    AST_OUT_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        !sl_load |=> $stable(out_byte)); // R8

    AST_IN_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> $stable(in_byte)); // R8

    AST_IN_LATEST: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> in_byte == $past(wr_byte)); // R9

endmodule

// File: rtl/hmb_mailbox.sv
module hmb_mailbox
    import hmb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sl_load,
    input  logic [DATA_W-1:0] sl_odata,
    input  logic              sl_read,
    output logic [DATA_W-1:0] sl_idata,
    input  logic              sl_f0_we,
    input  logic              sl_f0_val,
    output logic              sl_obf,
    output logic              sl_ibf,
    output logic              sl_cmd
);
    hmb_status_t          status;
    hmb_host_evt_t        evt;
    logic [DATA_W-1:0]    wr_byte;
    logic [DATA_W-1:0]    in_byte;
    logic [DATA_W-1:0]    out_byte;

    hmb_host_port #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_host (
        .clk(clk), .rst(rst),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_a0(host_a0), .host_wdata(host_wdata),
        .status(status), .out_byte(out_byte),
        .host_rdata(host_rdata), .evt(evt), .wr_byte(wr_byte)
    );

    hmb_flag_unit u_flags (
        .clk(clk), .rst(rst), .evt(evt),
        .sl_load(sl_load), .sl_read(sl_read),
        .sl_f0_we(sl_f0_we), .sl_f0_val(sl_f0_val),
        .status(status)
    );

    hmb_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst(rst),
        .wr_commit(evt.wr_done), .wr_byte(wr_byte),
        .sl_load(sl_load), .sl_odata(sl_odata),
        .in_byte(in_byte), .out_byte(out_byte)
    );

    assign sl_idata = in_byte;
    assign sl_obf   = status.obf;
    assign sl_ibf   = status.ibf;
    assign sl_cmd   = status.f1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status == '0 && in_byte == '0 && out_byte == '0)); // R1

endmodule

// File: tb/tb_hmb_mailbox.sv
module tb_hmb_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 8;
    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_cs = 0, host_rd = 0, host_wr = 0, host_a0 = 0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic sl_load = 0, sl_read = 0, sl_f0_we = 0, sl_f0_val = 0;
    logic [DW-1:0] sl_odata = '0;
    logic [DW-1:0] sl_idata;
    logic sl_obf, sl_ibf, sl_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] rb;
    logic exp_f1, exp_f0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmb_mailbox #(.DATA_W(DW), .SYNC_STAGES(STG)) dut (
        .clk(clk), .rst(rst),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_a0(host_a0), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sl_load(sl_load), .sl_odata(sl_odata), .sl_read(sl_read),
        .sl_idata(sl_idata), .sl_f0_we(sl_f0_we), .sl_f0_val(sl_f0_val),
        .sl_obf(sl_obf), .sl_ibf(sl_ibf), .sl_cmd(sl_cmd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] stat_word(input logic f1, input logic f0,
                                                input logic ibf, input logic obf);
        return {4'b0000, f1, f0, ibf, obf};
    endfunction

    task automatic host_write(input logic a0, input logic [DW-1:0] d);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_a0 = a0; host_wdata = d;
        ticks(2);
        host_wr = 0;
        ticks(STG + 2);
        host_cs = 0;
    endtask

    task automatic host_read(input logic a0, output logic [DW-1:0] d);
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_a0 = a0;
        ticks(2);
        d = host_rdata;
        host_rd = 0;
        ticks(STG + 2);
        host_cs = 0;
    endtask

    task automatic slave_load(input logic [DW-1:0] d);
        @(negedge clk);
        sl_load = 1; sl_odata = d;
        @(negedge clk);
        sl_load = 0;
    endtask

    task automatic slave_read();
        @(negedge clk);
        sl_read = 1;
        @(negedge clk);
        sl_read = 0;
    endtask

    task automatic slave_f0(input logic v);
        @(negedge clk);
        sl_f0_we = 1; sl_f0_val = v;
        @(negedge clk);
        sl_f0_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_f1 = 0; exp_f0 = 0;
        ticks(3);
        check(sl_obf == 0 && sl_ibf == 0 && sl_cmd == 0, "R1 flags in reset",
              {sl_obf, sl_ibf, sl_cmd}, 0);
        check(sl_idata == 0, "R1 inbound in reset", sl_idata, 0);
        rst = 0;
        ticks(2);
        host_read(1, rb);
        check(rb == 0, "R1 status after reset", rb, 0);
        host_read(0, rb);
        check(rb == 0, "R1 outbound after reset", rb, 0);

        // R10: no change while strobe held; update on the STG-th edge after release
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_a0 = 0; host_wdata = 8'hA5;
        ticks(6);
        check(sl_ibf == 0, "R10 held strobe", sl_ibf, 0);
        host_wr = 0;
        ticks(STG);
        check(sl_ibf == 0, "R10 before commit edge", sl_ibf, 0);
        ticks(1);
        check(sl_ibf == 1 && sl_idata == 8'hA5, "R10 at commit edge", {sl_ibf, sl_idata}, 9'h1A5);
        ticks(2);
        host_cs = 0;
        slave_read();

        // inbound sweep over every byte and both tags
        for (int v = 0; v < 256; v++) begin
            for (int a = 0; a < 2; a++) begin
                host_write(a[0], v[7:0]);
                exp_f1 = a[0];
                check(sl_idata == v[7:0], "R4 inbound byte", sl_idata, v);
                check(sl_ibf == 1, "R4 inbound flag set", sl_ibf, 1);
                check(sl_cmd == a[0], "R5 command tag", sl_cmd, a);
                check(sl_obf == 0, "R8 outbound flag untouched", sl_obf, 0);
                host_read(1, rb);
                check(rb == stat_word(exp_f1, exp_f0, 1, 0), "R7 status after write",
                      rb, stat_word(exp_f1, exp_f0, 1, 0));
                slave_read();
                check(sl_ibf == 0, "R4 slave read clears", sl_ibf, 0);
            end
        end

        // outbound sweep
        for (int v = 0; v < 256; v++) begin
            slave_load(v[7:0]);
            check(sl_obf == 1, "R2 outbound flag set", sl_obf, 1);
            check(sl_idata == 8'hFF && sl_ibf == 0, "R8 inbound untouched",
                  {sl_ibf, sl_idata}, 8'hFF);
            host_read(1, rb);
            check(rb == stat_word(exp_f1, exp_f0, 0, 1), "R7 status with outbound",
                  rb, stat_word(exp_f1, exp_f0, 0, 1));
            check(sl_obf == 1, "R7 status read keeps flag", sl_obf, 1);
            host_read(0, rb);
            check(rb == v[7:0], "R2 host reads slave byte", rb, v);
            check(sl_obf == 0, "R3 data read clears", sl_obf, 0);
        end

        // R3: host never reads back its own write
        slave_load(8'h3C);
        host_write(0, 8'hC3);
        exp_f1 = 0;
        host_read(0, rb);
        check(rb == 8'h3C, "R3 no own readback", rb, 8'h3C);
        check(sl_idata == 8'hC3, "R3 inbound kept", sl_idata, 8'hC3);
        slave_read();

        // R6: general flag
        slave_f0(1);
        exp_f0 = 1;
        host_read(1, rb);
        check(rb == stat_word(exp_f1, 1, 0, 0), "R6 general flag set", rb, stat_word(exp_f1, 1, 0, 0));
        host_write(1, 8'hFF);
        exp_f1 = 1;
        host_read(1, rb);
        check(rb == stat_word(1, 1, 1, 0), "R6 host write keeps flag", rb, stat_word(1, 1, 1, 0));
        slave_read();
        slave_f0(0);
        exp_f0 = 0;
        host_read(1, rb);
        check(rb == stat_word(1, 0, 0, 0), "R6 general flag clear", rb, stat_word(1, 0, 0, 0));

        // R9: overwrite while full
        host_write(0, 8'h01);
        host_write(0, 8'h02);
        exp_f1 = 0;
        check(sl_ibf == 1 && sl_idata == 8'h02, "R9 inbound overwrite", {sl_ibf, sl_idata}, 9'h102);
        slave_load(8'h10);
        slave_load(8'h20);
        check(sl_obf == 1, "R9 outbound flag stays", sl_obf, 1);
        host_read(0, rb);
        check(rb == 8'h20, "R9 outbound overwrite", rb, 8'h20);
        slave_read();

        // R12: strobes without chip select
        slave_load(8'h77);
        @(negedge clk);
        host_cs = 0; host_wr = 1; host_a0 = 1; host_wdata = 8'h99;
        ticks(3);
        host_wr = 0;
        ticks(STG + 2);
        host_rd = 1; host_a0 = 0;
        ticks(2);
        check(host_rdata == 0, "R12 rdata without cs", host_rdata, 0);
        host_rd = 0;
        ticks(STG + 2);
        check(sl_ibf == 0 && sl_idata == 8'h02 && sl_cmd == 0, "R12 write ignored",
              {sl_ibf, sl_cmd, sl_idata}, 8'h02);
        check(sl_obf == 1, "R12 read ignored", sl_obf, 1);
        host_read(0, rb);

        // R11: outbound collision sweep
        for (int d = 0; d < 6; d++) begin
            slave_load(8'h11);
            @(negedge clk);
            host_cs = 1; host_rd = 1; host_a0 = 0;
            ticks(2);
            host_rd = 0;
            for (int i = 0; i < 6; i++) begin
                sl_load = (i == d); sl_odata = 8'h40 + d[7:0];
                @(negedge clk);
            end
            sl_load = 0;
            host_cs = 0;
            ticks(1);
            check(sl_obf == (d >= STG), "R11 outbound collision", sl_obf, (d >= STG));
            if (sl_obf) begin
                host_read(0, rb);
                check(rb == 8'h40 + d[7:0], "R11 outbound byte", rb, 8'h40 + d);
            end
        end

        // R11: inbound collision sweep
        for (int d = 0; d < 6; d++) begin
            host_write(0, 8'h20);
            @(negedge clk);
            host_cs = 1; host_wr = 1; host_a0 = 0; host_wdata = 8'h30 + d[7:0];
            ticks(2);
            host_wr = 0;
            for (int i = 0; i < 6; i++) begin
                sl_read = (i == d);
                @(negedge clk);
            end
            sl_read = 0;
            host_cs = 0;
            ticks(1);
            check(sl_ibf == (d <= STG), "R11 inbound collision", sl_ibf, (d <= STG));
            check(sl_idata == 8'h30 + d[7:0], "R11 inbound byte", sl_idata, 8'h30 + d);
            if (sl_ibf) slave_read();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule